// File: doc/BRIEF.md
# Time Base and Decrementer Counter Pair

This block holds two counters that share one tick enable. The first is a 64-bit time base that counts up without stopping. The second is a 32-bit decrementer that counts down. Software reaches both through one write port and one registered read port. A 2-bit selector picks the lower time-base word, the upper time-base word or the decrementer. The time base is split into two 32-bit words, and a write to one word leaves the other word as it is.

The decrementer raises an exception request when its sign bit goes from clear to set. This happens when a count passes through zero, or when software writes a value with the sign bit set over a value whose sign bit is clear. When a count passes zero, the decrementer reloads all ones. The request is held as a sticky pending flag until a clear pulse arrives. In coarse clock mode, reads and writes of the lower time-base word pass through a fixed field mask, which gives a real-time-clock style view of the counter.

Top module: `timebase_decr`

## Requirements
- R1: After reset the time base is 0, the decrementer is 0xFFFFFFFF, the pending flag is 0 and rd_data is 0.
- R2: Each cycle with tick_en high and no write to the time base, the 64-bit time base goes up by one, and a carry passes from the lower word into the upper word.
- R3: A write with sel=1 replaces bits 63:32 and keeps bits 31:0. A write with sel=0 replaces bits 31:0 and keeps bits 63:32.
- R4: Each cycle with tick_en high and no decrementer write (sel=2), a non-zero decrementer goes down by one. A read with sel=2 returns its value.
- R5: A decrementer write whose bit 31 is 1 sets the pending flag when the current decrementer bit 31 is 0. A write whose bit 31 is 0, or a write made while the current bit 31 is 1, does not set the flag.
- R6: A tick while the decrementer holds 0 loads 0xFFFFFFFF and sets the pending flag.
- R7: The pending flag stays set until exc_clr is pulsed. An event in the same cycle as exc_clr leaves the flag set.
- R8: A write in the same cycle as a tick takes priority. The written register takes the written value and does not tick in that cycle.
- R9: With rtc_mode high, both writes and reads of the lower time-base word are ANDed with 0x3FFFFF80.
- R10: rd_data is registered. It shows the word chosen by rd_sel one clock after that selection (0 lower, 1 upper, 2 decrementer), and rd_sel=3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances both counters |
| rtc_mode | input | 1 | Masks the lower time-base word |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 lower, 1 upper, 2 decrementer |
| wr_data | input | 32 | Write value |
| rd_sel | input | 2 | Read source: 0 lower, 1 upper, 2 decrementer, 3 none |
| rd_data | output | 32 | Registered read data |
| exc_clr | input | 1 | Clears the pending flag |
| exc_pend | output | 1 | Sticky decrementer exception request |

## Verification
A lower time-base word preloaded just below wraparound shows that the carry reaches the upper word. Separate half-word writes show that each write leaves the other word untouched. Decrementer writes are tried in three cases: a positive value, a negative value over a negative value, and a negative value over a positive value. Only the last case may raise the flag. A countdown through zero, a write coinciding with a tick, and a clear coinciding with an expiry show the reload, the priority rule and the sticky rule. Coarse clock mode is tried on an all-ones write and on a value written in normal mode, which checks that the mask applies to both writes and reads.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } tbd_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int          DW       = 32,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rtc_mode,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] tb_q
);
  localparam logic [DW-1:0] MASK_W = DW'(RTC_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_q <= '0;
    end else if (wr_lo) begin
      tb_q[DW-1:0] <= rtc_mode ? (wr_data & MASK_W) : wr_data;
    end else if (wr_hi) begin
      tb_q[2*DW-1:DW] <= wr_data;
    end else if (tick) begin
      tb_q <= tb_q + 1'b1;
    end
  end

  // R2: a free tick advances the full width by one
  a_r2_tb_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_lo && !wr_hi) |=> (tb_q == $past(tb_q) + 1'b1));
  // R3: an upper write keeps the lower word
  a_r3_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (tb_q[DW-1:0] == $past(tb_q[DW-1:0])));
  // R3: a lower write keeps the upper word
  a_r3_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (tb_q[2*DW-1:DW] == $past(tb_q[2*DW-1:DW])));
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] dec_q,
  output logic          evt
);
  localparam int MSB = DW - 1;

  logic expire;
  logic neg_write;

  assign expire    = !wr && tick && (dec_q == '0);
  assign neg_write = wr && wr_data[MSB] && !dec_q[MSB];
  assign evt       = expire || neg_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= '1;
    end else if (wr) begin
      dec_q <= wr_data;
    end else if (tick) begin
      dec_q <= dec_q - 1'b1;
    end
  end

  // R4: a free tick on a non-zero count steps down by one
  a_r4_dec_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && (dec_q != '0)) |=> (dec_q == $past(dec_q) - 1'b1));
  // R6: passing zero reloads all ones
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && (dec_q == '0)) |=> (&dec_q));
  // R8: a write wins over the tick
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> (dec_q == $past(wr_data)));
endmodule

// File: rtl/tbd_pend_flag.sv
module tbd_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend && !clr) || evt;
  end

  // R7: the flag holds without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
  // R7: an event beats a simultaneous clear
  a_r7_evt_beats_clr: assert property (@(posedge clk) disable iff (rst)
    evt |=> pend);
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
  import tbd_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_en,
  input  logic          rtc_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          exc_clr,
  output logic          exc_pend
);
  localparam int            TBW    = 2 * DW;
  localparam logic [DW-1:0] MASK_W = DW'(RTC_MASK);

  tbd_sel_e        wsel, rsel;
  logic            wr_lo, wr_hi, wr_dec;
  logic [TBW-1:0]  tb_q;
  logic [DW-1:0]   dec_q;
  logic            dec_evt;
  logic [DW-1:0]   rd_next;

  assign wsel   = tbd_sel_e'(wr_sel);
  assign rsel   = tbd_sel_e'(rd_sel);
  assign wr_lo  = wr_en && (wsel == SEL_TB_LO);
  assign wr_hi  = wr_en && (wsel == SEL_TB_HI);
  assign wr_dec = wr_en && (wsel == SEL_DEC);

  tbd_timebase #(.DW(DW), .RTC_MASK(RTC_MASK)) u_tb (
    .clk(clk), .rst(rst), .tick(tick_en), .rtc_mode(rtc_mode),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .tb_q(tb_q)
  );

  tbd_decrementer #(.DW(DW)) u_dec (
    .clk(clk), .rst(rst), .tick(tick_en), .wr(wr_dec),
    .wr_data(wr_data), .dec_q(dec_q), .evt(dec_evt)
  );

  tbd_pend_flag u_pend (
    .clk(clk), .rst(rst), .evt(dec_evt), .clr(exc_clr), .pend(exc_pend)
  );

  always_comb begin
    unique case (rsel)
      SEL_TB_LO: rd_next = rtc_mode ? (tb_q[DW-1:0] & MASK_W) : tb_q[DW-1:0];
      SEL_TB_HI: rd_next = tb_q[TBW-1:DW];
      SEL_DEC:   rd_next = dec_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R9: a masked-mode lower read never shows bits outside the field
  a_r9_rtc_read: assert property (@(posedge clk) disable iff (rst)
    (rtc_mode && rsel == SEL_TB_LO) |=> ((rd_data & ~MASK_W) == '0));
  // R5: a negative write over a positive count raises the request
  a_r5_neg_write: assert property (@(posedge clk) disable iff (rst)
    (wr_dec && wr_data[DW-1] && !dec_q[DW-1]) |=> exc_pend);
  // R10: the unused selector reads zero
  a_r10_none_zero: assert property (@(posedge clk) disable iff (rst)
    (rsel == SEL_NONE) |=> (rd_data == '0));
endmodule

// File: tb/timebase_decr_tb_top.sv
module timebase_decr_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en, rtc_mode, wr_en, exc_clr;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        exc_pend;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  timebase_decr dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rtc_mode(rtc_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .exc_clr(exc_clr), .exc_pend(exc_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_sel = s;
    @(negedge clk); v = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic clr_pend();
    @(negedge clk); exc_clr = 1;
    @(negedge clk); exc_clr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pend", 32'(exc_pend), 0);
    chk("R1 rd_data", rd_data, 0);
    rd(2'd0, v); chk("R1 tb lo", v, 0);
    rd(2'd1, v); chk("R1 tb hi", v, 0);
    rd(2'd2, v); chk("R1 dec", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_carry();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFE);
    wr(2'd1, 32'h0000_0005);
    ticks(3);
    rd(2'd0, v); chk("R2 carry lo", v, 32'h0000_0001);
    rd(2'd1, v); chk("R2 carry hi", v, 32'h0000_0006);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    wr(2'd0, 32'h0000_1234);
    wr(2'd1, 32'h0000_ABCD);
    rd(2'd0, v); chk("R3 hi write keeps lo", v, 32'h0000_1234);
    wr(2'd0, 32'h0000_7777);
    rd(2'd1, v); chk("R3 lo write keeps hi", v, 32'h0000_ABCD);
  endtask

  task automatic t_count_down();
    logic [31:0] v;
    wr(2'd2, 32'd10);
    ticks(4);
    rd(2'd2, v); chk("R4 dec value", v, 32'd6);
    chk("R5 positive write no pend", 32'(exc_pend), 0);
  endtask

  task automatic t_expiry();
    logic [31:0] v;
    wr(2'd2, 32'd2);
    ticks(2);
    rd(2'd2, v); chk("R6 at zero", v, 0);
    chk("R6 no pend at zero", 32'(exc_pend), 0);
    ticks(1);
    rd(2'd2, v); chk("R6 reload", v, 32'hFFFF_FFFF);
    chk("R6 pend set", 32'(exc_pend), 1);
    repeat (3) @(negedge clk);
    chk("R7 sticky", 32'(exc_pend), 1);
    clr_pend();
    chk("R7 cleared", 32'(exc_pend), 0);
  endtask

  task automatic t_neg_write();
    wr(2'd2, 32'h8000_0000);
    chk("R5 neg over neg no pend", 32'(exc_pend), 0);
    wr(2'd2, 32'd5);
    wr(2'd2, 32'h9000_0000);
    chk("R5 neg over pos pend", 32'(exc_pend), 1);
    clr_pend();
  endtask

  task automatic t_clr_collide();
    wr(2'd2, 32'd0);
    @(negedge clk); tick_en = 1; exc_clr = 1;
    @(negedge clk); tick_en = 0; exc_clr = 0;
    chk("R7 event beats clear", 32'(exc_pend), 1);
    clr_pend();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    @(negedge clk); tick_en = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 32'd100;
    @(negedge clk); wr_sel = 2'd0; wr_data = 32'h0000_0040;
    @(negedge clk); wr_en = 0; tick_en = 0;
    rd(2'd2, v); chk("R8 dec write wins", v, 32'd99);
    rd(2'd0, v); chk("R8 tb write wins", v, 32'h0000_0040);
  endtask

  task automatic t_rtc();
    logic [31:0] v;
    wr(2'd0, 32'h1234_5678);
    @(negedge clk); rtc_mode = 1;
    rd(2'd0, v); chk("R9 masked read", v, 32'h1234_5600);
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); rtc_mode = 0;
    rd(2'd0, v); chk("R9 masked write", v, 32'h3FFF_FF80);
  endtask

  task automatic t_read_path();
    logic [31:0] v;
    rd(2'd3, v); chk("R10 sel3 zero", v, 0);
    wr(2'd1, 32'h0000_00AA);
    @(negedge clk); rd_sel = 2'd1;
    @(posedge clk); #1;
    chk("R10 one cycle latency", rd_data, 32'h0000_00AA);
  endtask

  initial begin
    rst = 1; tick_en = 0; rtc_mode = 0; wr_en = 0; exc_clr = 0;
    wr_sel = 0; rd_sel = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_carry();
    t_halves();
    t_count_down();
    t_expiry();
    t_neg_write();
    t_clr_collide();
    t_priority();
    t_rtc();
    t_read_path();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule